// File: doc/BRIEF.md
# H-bridge gate sequencer with deadtime and decay modes

This block turns a small set of control bits for one full bridge into the four gate-drive signals of that bridge. The bridge has two legs, and each leg has a high switch and a low switch. A phase bit selects which diagonal pair conducts. An off-time request makes the bridge recirculate. A decay select then picks between two recirculation patterns. Fast decay lets the current fall steeply, keeping only a low switch on for synchronous rectification. Slow decay lets the current circulate through the two high switches.

All changes go through a cross-conduction guard. A switch that leaves the wanted pattern is released at once, in the same cycle, without waiting for a clock edge. A switch that joins the pattern waits a programmable number of clock edges, `DEAD_CYCLES`. At 100 MHz the default of 100 edges gives 1 µs. The wanted pattern is then in force. A global enable, a fault input and a per-bridge enable each force all four gates low at once. The phase sequencer upstream drives the control bits. The block's outputs feed the gate drivers.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With chipEnable=1, fault=0, bridgeEn=1 and chopOff=0, the settled gates follow phase. phase=1 gives hiLeg1 and loLeg2 on with the others off. phase=0 gives hiLeg2 and loLeg1 on with the others off.
- R2: With the block enabled, chopOff=1 and slowDecay=0 (fast decay), both high gates are off. After the deadtime only one low gate is on: loLeg1 when phase=1, loLeg2 when phase=0.
- R3: With the block enabled, chopOff=1 and slowDecay=1 (slow decay), both low gates are off and the settled pattern is hiLeg1 and hiLeg2. A high gate that was already on stays on without a gap.
- R4: A gate that is not part of the pattern selected by the present inputs goes low combinationally, in the same cycle as the input change.
- R5: A gate that joins the pattern asserts only once the selected pattern has been seen unchanged on DEAD_CYCLES further rising edges after the edge where it changed. Any change inside that window restarts it. A gate present in both the old and the new pattern stays on.
- R6: hiLeg1 and loLeg1 are never high together, and hiLeg2 and loLeg2 are never high together.
- R7: Before a gate turns on, the other gate of its leg has been low for at least DEAD_CYCLES clock cycles.
- R8: chipEnable=0, fault=1 or bridgeEn=0 forces all four gates low in the same cycle. After re-enable, gates turn on only after the R5 deadtime, counted from the all-off state.
- R9: While rst_n is low, all four gates are low whatever the other inputs are.
- R10: A phase reversal while driving passes through an interval of DEAD_CYCLES cycles in which all four gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chipEnable | input | 1 | Global enable; low turns every gate off |
| fault | input | 1 | Protection fault; high turns every gate off |
| bridgeEn | input | 1 | Bridge enable from the phase sequencer |
| phase | input | 1 | Current direction: 1 drives leg 1 high side to leg 2 low side |
| chopOff | input | 1 | Chopping off-time request |
| slowDecay | input | 1 | Decay select: 1 slow, 0 fast |
| hiLeg1 | output | 1 | Leg 1 high-side gate |
| loLeg1 | output | 1 | Leg 1 low-side gate |
| hiLeg2 | output | 1 | Leg 2 high-side gate |
| loLeg2 | output | 1 | Leg 2 low-side gate |

## Verification
The bench goes after three kinds of transition. The first is the move into and out of each decay pattern, where a design that delayed the turn-off, or let the kept high switch drop during slow decay, would show up as an early release or a one-cycle gap. The second is a phase reversal, where a design that moved straight from one diagonal to the other would drive both switches of a leg. The third is a pattern that changes back inside its own deadtime, where a design that did not restart the window would turn a switch on too early. Fault, global and bridge disables are raised while the bridge is driving, to catch gates that linger for a cycle. The turn-on after each re-enable is timed edge by edge against the deadtime.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Gate vector bit positions
  localparam int G_HI1 = 0;
  localparam int G_LO1 = 1;
  localparam int G_HI2 = 2;
  localparam int G_LO2 = 3;
  localparam int N_GATES = 4;

  typedef logic [N_GATES-1:0] gateVec_t;

  // Strobes from the deadtime control to the gate datapath
  typedef struct packed {
    logic restart;  // target changed at this edge
    logic hold;     // no new turn-on allowed at this edge
  } seqStrobe_t;
endpackage

// File: rtl/hbg_pattern.sv
module hbg_pattern
  import hbg_pkg::*;
(
  input  logic     allowed,
  input  logic     phase,
  input  logic     chopOff,
  input  logic     slowDecay,
  output gateVec_t tgt
);
  always_comb begin
    tgt = '0;
    if (allowed) begin
      if (!chopOff) begin
        // drive: one diagonal
        tgt[G_HI1] = phase;
        tgt[G_LO2] = phase;
        tgt[G_HI2] = !phase;
        tgt[G_LO1] = !phase;
      end else if (slowDecay) begin
        // recirculate around the upper half
        tgt[G_HI1] = 1'b1;
        tgt[G_HI2] = 1'b1;
      end else begin
        // quasi-synchronous: low switch beside the conducting freewheel path
        tgt[G_LO1] = phase;
        tgt[G_LO2] = !phase;
      end
    end
  end
endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gateVec_t   tgt,
  output seqStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYCLES - 1);

  gateVec_t prevTgt;
  logic [CNT_W-1:0] cnt;
  logic changed;

  assign changed        = (tgt != prevTgt);
  assign strobe.restart = changed;
  assign strobe.hold    = changed || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevTgt <= '0;
      cnt     <= '0;
    end else begin
      prevTgt <= tgt;
      if (changed)
        cnt <= LOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  // R5: a restart always leaves a non-zero window unless the deadtime is one edge
  p_restart_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && DEAD_CYCLES > 1) |=> (cnt != '0));
endmodule

// File: rtl/hbg_gates.sv
module hbg_gates
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gateVec_t   tgt,
  input  seqStrobe_t strobe,
  output gateVec_t   gates
);
  localparam int OFF_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(DEAD_CYCLES);

  gateVec_t gateQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gateQ <= '0;
    else if (strobe.hold)
      gateQ <= gateQ & tgt;   // only releases while the deadtime runs
    else
      gateQ <= tgt;
  end

  // released switches drop without waiting for an edge
  assign gates = gateQ & tgt;

  // R5: no switch is added on a held edge
  p_no_turnon_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.hold |=> ((gateQ & ~$past(gateQ)) == '0));

  p_no_turnon_at_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restart |=> ((gates & ~$past(gates)) == '0));

  for (genvar leg = 0; leg < 2; leg++) begin : g_leg
    localparam int HI = 2 * leg;
    localparam int LO = 2 * leg + 1;
    logic [OFF_W-1:0] offHi;
    logic [OFF_W-1:0] offLo;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offHi <= '0;
        offLo <= '0;
      end else begin
        if (gates[HI]) offHi <= '0;
        else if (offHi != OFF_SAT) offHi <= offHi + 1'b1;
        if (gates[LO]) offLo <= '0;
        else if (offLo != OFF_SAT) offLo <= offLo + 1'b1;
      end
    end

    p_leg_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(gates[HI] && gates[LO]));

    p_hi_after_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gates[HI]) |-> (offLo >= OFF_SAT));

    p_lo_after_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gates[LO]) |-> (offHi >= OFF_SAT));
  end
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chipEnable,
  input  logic fault,
  input  logic bridgeEn,
  input  logic phase,
  input  logic chopOff,
  input  logic slowDecay,
  output logic hiLeg1,
  output logic loLeg1,
  output logic hiLeg2,
  output logic loLeg2
);
  logic       allowed;
  gateVec_t   tgt;
  gateVec_t   gates;
  seqStrobe_t strobe;

  assign allowed = chipEnable && !fault && bridgeEn;

  hbg_pattern u_pattern (
    .allowed  (allowed),
    .phase    (phase),
    .chopOff  (chopOff),
    .slowDecay(slowDecay),
    .tgt      (tgt)
  );

  hbg_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .tgt   (tgt),
    .strobe(strobe)
  );

  hbg_gates #(.DEAD_CYCLES(DEAD_CYCLES)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .tgt   (tgt),
    .strobe(strobe),
    .gates (gates)
  );

  assign hiLeg1 = gates[G_HI1];
  assign loLeg1 = gates[G_LO1];
  assign hiLeg2 = gates[G_HI2];
  assign loLeg2 = gates[G_LO2];

  p_disable_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chipEnable || fault || !bridgeEn) |-> !(hiLeg1 || loLeg1 || hiLeg2 || loLeg2));

  p_reenable_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(allowed) |=> !(hiLeg1 || loLeg1 || hiLeg2 || loLeg2));

  p_drive_diagonal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed && !chopOff) |->
      (phase ? !(hiLeg2 || loLeg1) : !(hiLeg1 || loLeg2)));

  p_fast_no_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed && chopOff && !slowDecay) |-> !(hiLeg1 || hiLeg2));

  p_slow_no_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed && chopOff && slowDecay) |-> !(loLeg1 || loLeg2));
endmodule

// File: tb/hbridge_gate_seq_bench.sv
`timescale 1ns/1ps
module hbridge_gate_seq_bench;
  localparam int D = 20;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipEnable = 1'b0, fault = 1'b0, bridgeEn = 1'b0;
  logic phase = 1'b0, chopOff = 1'b0, slowDecay = 1'b0;
  logic hiLeg1, loLeg1, hiLeg2, loLeg2;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [3:0] gateExp = '0;
  logic [3:0] lastTgt = '0;
  logic [3:0] prevOuts = '0;
  int held = 0;
  int offRun [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYCLES(D)) u_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .chipEnable(chipEnable), .fault(fault),
    .bridgeEn(bridgeEn), .phase(phase), .chopOff(chopOff), .slowDecay(slowDecay),
    .hiLeg1(hiLeg1), .loLeg1(loLeg1), .hiLeg2(hiLeg2), .loLeg2(loLeg2)
  );

  // bit0 hiLeg1, bit1 loLeg1, bit2 hiLeg2, bit3 loLeg2
  function automatic logic [3:0] outs();
    return {loLeg2, hiLeg2, loLeg1, hiLeg1};
  endfunction

  function automatic logic [3:0] patternOf(logic en, logic flt, logic ben,
                                           logic ph, logic chop, logic slow);
    if (!en || flt || !ben) return 4'b0000;
    if (!chop) return ph ? 4'b1001 : 4'b0110;
    if (!slow) return ph ? 4'b0010 : 4'b1000;
    return 4'b0101;
  endfunction

  function automatic logic [3:0] curTgt();
    return patternOf(chipEnable, fault, bridgeEn, phase, chopOff, slowDecay);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] act,
                     input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: sample after the rising edge, update model, compare
  task automatic tick();
    logic [3:0] t;
    logic [3:0] o;
    string tag;
    @(negedge clk);
    o = outs();
    if (!rst_n) begin
      gateExp = '0; lastTgt = '0; held = 0; prevOuts = '0;
      for (int i = 0; i < 4; i++) offRun[i] = 0;
      chk(o == 4'b0000, "R9 reset", o, 4'b0000);
      return;
    end
    t = curTgt();
    if (t == lastTgt) begin
      if (held < 100000) held++;
    end else begin
      held = 0;
    end
    lastTgt = t;
    if (held >= D) gateExp = t;
    else gateExp = gateExp & t;
    if (t == 4'b0000) tag = "R8 disabled";
    else if (held < D) tag = "R5 deadtime";
    else if (!chopOff) tag = "R1 drive";
    else if (slowDecay) tag = "R3 slow";
    else tag = "R2 fast";
    chk(o == gateExp, tag, o, gateExp);
    chk(!(o[0] && o[1]) && !(o[2] && o[3]), "R6 leg", o, gateExp);
    for (int i = 0; i < 4; i++) begin
      if (o[i] && !prevOuts[i])
        chk(offRun[i ^ 1] >= D, "R7 partner", o, gateExp);
    end
    for (int i = 0; i < 4; i++) offRun[i] = o[i] ? 0 : offRun[i] + 1;
    prevOuts = o;
  endtask

  task automatic setIn(input logic en, input logic flt, input logic ben,
                       input logic ph, input logic chop, input logic slow);
    logic [3:0] e;
    chipEnable = en; fault = flt; bridgeEn = ben;
    phase = ph; chopOff = chop; slowDecay = slow;
    #1;
    if (rst_n) begin
      e = gateExp & curTgt();
      if (curTgt() == 4'b0000) chk(outs() == 4'b0000, "R8 immediate off", outs(), 4'b0000);
      else chk(outs() == e, "R4 immediate release", outs(), e);
    end
  endtask

  // n ticks, each ending with an explicit expectation
  task automatic hold(input int n, input logic [3:0] exp, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(outs() == exp, tag, outs(), exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    // reset dominates active inputs
    chipEnable = 1; bridgeEn = 1; phase = 1;
    hold(3, 4'b0000, "R9 reset with drive inputs");
    setIn(0, 0, 1, 1, 0, 0);
    rst_n = 1'b1;
    hold(3, 4'b0000, "R8 disabled after reset");

    // drive phase 1
    setIn(1, 0, 1, 1, 0, 0);
    hold(D, 4'b0000, "R5 first turn-on wait");
    hold(2, 4'b1001, "R1 phase1 diagonal");
    // fast decay phase 1
    setIn(1, 0, 1, 1, 1, 0);
    chk(outs() == 4'b0000, "R2 fast decay all off", outs(), 4'b0000);
    hold(D, 4'b0000, "R2 fast decay deadtime");
    hold(2, 4'b0010, "R2 fast decay low leg1");
    // back to drive
    setIn(1, 0, 1, 1, 0, 0);
    hold(D, 4'b0000, "R5 return after fast decay");
    hold(2, 4'b1001, "R1 phase1 restored");
    // slow decay phase 1
    setIn(1, 0, 1, 1, 1, 1);
    chk(outs() == 4'b0001, "R3 slow keeps hiLeg1", outs(), 4'b0001);
    hold(D, 4'b0001, "R3 slow deadtime");
    hold(2, 4'b0101, "R3 slow both highs");
    setIn(1, 0, 1, 1, 0, 0);
    hold(D, 4'b0001, "R5 return after slow decay");
    hold(2, 4'b1001, "R1 phase1 after slow");
    // reversal
    setIn(1, 0, 1, 0, 0, 0);
    chk(outs() == 4'b0000, "R10 reversal off", outs(), 4'b0000);
    hold(D, 4'b0000, "R10 reversal all-off window");
    hold(2, 4'b0110, "R1 phase0 diagonal");
    // fast and slow decay phase 0
    setIn(1, 0, 1, 0, 1, 0);
    hold(D, 4'b0000, "R2 fast phase0 deadtime");
    hold(2, 4'b1000, "R2 fast decay low leg2");
    setIn(1, 0, 1, 0, 1, 1);
    hold(D, 4'b0000, "R5 fast to slow");
    hold(2, 4'b0101, "R3 slow phase0");
    setIn(1, 0, 1, 0, 0, 0);
    hold(D, 4'b0100, "R3 hiLeg2 kept on exit");
    hold(2, 4'b0110, "R1 phase0 restored");
    // change back inside the window restarts it
    setIn(1, 0, 1, 0, 1, 0);
    hold(3, 4'b0000, "R5 short off-time");
    setIn(1, 0, 1, 0, 0, 0);
    hold(D, 4'b0000, "R5 restarted window");
    hold(2, 4'b0110, "R5 on after restart");
    // fault, bridge enable, global enable
    setIn(1, 1, 1, 0, 0, 0);
    hold(4, 4'b0000, "R8 fault off");
    setIn(1, 0, 1, 0, 0, 0);
    hold(D, 4'b0000, "R8 deadtime after fault");
    hold(2, 4'b0110, "R8 on after fault");
    setIn(1, 0, 0, 0, 0, 0);
    hold(4, 4'b0000, "R8 bridge disable");
    setIn(1, 0, 1, 1, 0, 0);
    hold(D, 4'b0000, "R8 deadtime after bridge enable");
    hold(2, 4'b1001, "R8 on after bridge enable");
    setIn(0, 0, 1, 1, 0, 0);
    hold(4, 4'b0000, "R8 global disable");

    // constrained random segments
    for (int s = 0; s < 500; s++) begin
      int len;
      setIn(($urandom_range(0, 9) != 0), ($urandom_range(0, 19) == 0),
            ($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 9) < 4), 1'($urandom_range(0, 1)));
      len = $urandom_range(1, 3 * D);
      for (int c = 0; c < len; c++) tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule